// File: doc/BRIEF.md
# Iterative HI/LO Multiply-Divide Unit

This block sits beside a 32-bit processor datapath and performs integer multiplication and division over many cycles. It does not write its results into the general register file. Instead it keeps two dedicated result registers, HI and LO. A multiply leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO. The host reads either register back with a move command, which returns the value on a 32-bit read port.

A command is issued by pulsing `start_i` for one cycle with a code on `cmd_i` and operands on `op_a_i` / `op_b_i`. Multiply uses a shift-add loop and divide a restoring shift-subtract loop, each 32 iterations long. Both come in signed (two's complement) and unsigned forms. Signed operands are reduced to magnitudes first, and the signs are applied to the results at the end. While an operation runs, `busy_o` is high. A move issued during that time is remembered and answered as the result lands. Any other command issued while busy is dropped.

The controller is a four-state machine. `ST_IDLE` accepts commands. An accepted multiply goes to `ST_MUL` and an accepted divide goes to `ST_DIV`. Each of these two states runs `WIDTH` iteration cycles and then goes to `ST_FIX`. `ST_FIX` applies the signs, writes HI and LO, answers any held move, and always returns to `ST_IDLE`. Moves and unused codes leave the machine in `ST_IDLE`.

Top module: `hilo_muldiv`

## Requirements
- R1: Command code 0 (unsigned multiply) writes bits 63..32 of the 64-bit product of the operands to HI and bits 31..0 to LO.
- R2: Command code 1 (signed multiply) treats both operands as two's complement values in the range -2,147,483,648 to 2,147,483,647 and stores the signed 64-bit product split as in R1.
- R3: Command code 2 (unsigned divide) with a non-zero divisor puts the quotient of `op_a_i` / `op_b_i` in LO and the remainder in HI.
- R4: Command code 3 (signed divide) with a non-zero divisor rounds the quotient toward zero, so the quotient is negative when the operand signs differ. The remainder carries the sign of the dividend. The quotient of -2,147,483,648 by -1 wraps to 0x80000000 with remainder 0.
- R5: A divide (code 2 or 3) by zero leaves LO = 0xFFFFFFFF and HI = the dividend as given, and raises no error.
- R6: With the unit idle, command code 4 reads HI and code 5 reads LO. `rd_valid_o` is high in the cycle after the strobe, and `rd_data_o` then carries the register's contents.
- R7: An accepted multiply or divide raises `busy_o` in the cycle after the strobe, and `busy_o` stays high for exactly 33 cycles (32 iterations plus one fix-up cycle).
- R8: A move strobed while busy (including in the last busy cycle) is held. `rd_valid_o` stays low while `busy_o` is high, and it rises in the cycle `busy_o` falls, carrying the new result.
- R9: A multiply or divide strobe while busy is ignored. The running operation's timing and results are unchanged.
- R10: After reset, HI and LO read as zero, and `busy_o` and `rd_valid_o` are low.
- R11: Command codes 6 and 7 have no effect: `busy_o` and `rd_valid_o` stay low and HI/LO keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle command strobe |
| cmd_i | input | 3 | Command code (0..5 used, see R1-R6) |
| op_a_i | input | 32 | Multiplicand or dividend |
| op_b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while a multiply or divide is in progress |
| rd_valid_o | output | 1 | Read data valid for one cycle |
| rd_data_o | output | 32 | HI or LO contents returned by a move |

## Verification
The delicate overlap is a move arriving in the same cycle as an operation completing: the read must return the freshly computed value, not the old HI/LO. The bench provokes this by strobing a move in the 33rd busy cycle, the cycle in which the fix-up state writes the results. It also strobes a move early in the run. In both cases it expects `rd_valid_o` to stay low while `busy_o` is high and to rise together with the fall of `busy_o`, carrying the value its own model computes. A second overlap, a new operation strobed mid-run, is judged by the unchanged busy length and the first operation's results.

// File: rtl/hilo_muldiv_pkg.sv
package hilo_muldiv_pkg;

    localparam logic [2:0] CMD_MULU = 3'd0;
    localparam logic [2:0] CMD_MULS = 3'd1;
    localparam logic [2:0] CMD_DIVU = 3'd2;
    localparam logic [2:0] CMD_DIVS = 3'd3;
    localparam logic [2:0] CMD_RDHI = 3'd4;
    localparam logic [2:0] CMD_RDLO = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIX  = 2'd3
    } md_state_t;

endpackage

// File: rtl/hilo_operand_prep.sv
module hilo_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             signed_i,
    output logic [WIDTH-1:0] mag_a_o,
    output logic [WIDTH-1:0] mag_b_o,
    output logic             a_neg_o,
    output logic             b_neg_o
);
    always_comb begin
        a_neg_o = signed_i & a_i[WIDTH-1];
        b_neg_o = signed_i & b_i[WIDTH-1];
        mag_a_o = a_neg_o ? (~a_i + 1'b1) : a_i;
        mag_b_o = b_neg_o ? (~b_i + 1'b1) : b_i;
    end
endmodule

// File: rtl/hilo_mul_step.sv
module hilo_mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc_hi_i,
    input  logic [WIDTH-1:0] acc_lo_i,
    input  logic [WIDTH-1:0] mcand_i,
    output logic [WIDTH-1:0] acc_hi_o,
    output logic [WIDTH-1:0] acc_lo_o
);
    logic [WIDTH:0] sum;

    always_comb begin
        sum = {1'b0, acc_hi_i} + (acc_lo_i[0] ? {1'b0, mcand_i} : '0);
        acc_hi_o = sum[WIDTH:1];
        acc_lo_o = {sum[0], acc_lo_i[WIDTH-1:1]};
    end
endmodule

// File: rtl/hilo_div_step.sv
module hilo_div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvsr_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] quo_o
);
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] diff;
    logic           fits;

    always_comb begin
        shifted = {rem_i, quo_i[WIDTH-1]};
        fits    = shifted >= {1'b0, dvsr_i};
        diff    = shifted - {1'b0, dvsr_i};
        rem_o   = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
        quo_o   = {quo_i[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/hilo_result_fix.sv
module hilo_result_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] raw_hi_i,
    input  logic [WIDTH-1:0] raw_lo_i,
    input  logic             is_div_i,
    input  logic             a_neg_i,
    input  logic             b_neg_i,
    input  logic             div_zero_i,
    input  logic [WIDTH-1:0] orig_a_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] prod;

    always_comb begin
        prod = {raw_hi_i, raw_lo_i};
        if (a_neg_i ^ b_neg_i) begin
            prod = ~prod + 1'b1;
        end
        if (!is_div_i) begin
            hi_o = prod[PW-1:WIDTH];
            lo_o = prod[WIDTH-1:0];
        end else if (div_zero_i) begin
            hi_o = orig_a_i;
            lo_o = '1;
        end else begin
            lo_o = (a_neg_i ^ b_neg_i) ? (~raw_lo_i + 1'b1) : raw_lo_i;
            hi_o = a_neg_i ? (~raw_hi_i + 1'b1) : raw_hi_i;
        end
    end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       cmd_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic             busy_o,
    output logic             rd_valid_o,
    output logic [WIDTH-1:0] rd_data_o
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    md_state_t state_q, state_d;

    logic [CNT_W-1:0] step_q;
    logic [WIDTH-1:0] acc_hi_q, acc_lo_q, opnd_b_q, orig_a_q;
    logic             a_neg_q, b_neg_q, is_div_q;
    logic [WIDTH-1:0] hi_q, lo_q;
    logic             pend_q, pend_hi_q;
    logic             rd_valid_q;
    logic [WIDTH-1:0] rd_data_q;

    // command decode
    logic is_arith, is_move, move_hi;
    always_comb begin
        is_arith = start_i & ~cmd_i[2];
        is_move  = start_i & (cmd_i == CMD_RDHI || cmd_i == CMD_RDLO);
        move_hi  = (cmd_i == CMD_RDHI);
    end

    // operand magnitudes
    logic [WIDTH-1:0] mag_a, mag_b;
    logic             a_neg, b_neg;
    hilo_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .a_i      (op_a_i),
        .b_i      (op_b_i),
        .signed_i (cmd_i[0]),
        .mag_a_o  (mag_a),
        .mag_b_o  (mag_b),
        .a_neg_o  (a_neg),
        .b_neg_o  (b_neg)
    );

    // iteration steps
    logic [WIDTH-1:0] mul_hi, mul_lo, div_rem, div_quo;
    hilo_mul_step #(.WIDTH(WIDTH)) u_mul (
        .acc_hi_i (acc_hi_q),
        .acc_lo_i (acc_lo_q),
        .mcand_i  (opnd_b_q),
        .acc_hi_o (mul_hi),
        .acc_lo_o (mul_lo)
    );
    hilo_div_step #(.WIDTH(WIDTH)) u_div (
        .rem_i  (acc_hi_q),
        .quo_i  (acc_lo_q),
        .dvsr_i (opnd_b_q),
        .rem_o  (div_rem),
        .quo_o  (div_quo)
    );

    // sign application
    logic [WIDTH-1:0] fin_hi, fin_lo;
    logic             div_zero;
    always_comb div_zero = (opnd_b_q == '0);
    hilo_result_fix #(.WIDTH(WIDTH)) u_fix (
        .raw_hi_i   (acc_hi_q),
        .raw_lo_i   (acc_lo_q),
        .is_div_i   (is_div_q),
        .a_neg_i    (a_neg_q),
        .b_neg_i    (b_neg_q),
        .div_zero_i (div_zero),
        .orig_a_i   (orig_a_q),
        .hi_o       (fin_hi),
        .lo_o       (fin_lo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_arith) begin
                    state_d = cmd_i[1] ? ST_DIV : ST_MUL;
                end
            end
            ST_MUL, ST_DIV: begin
                if (step_q == LAST_STEP) begin
                    state_d = ST_FIX;
                end
            end
            ST_FIX: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q    <= '0;
            acc_hi_q  <= '0;
            acc_lo_q  <= '0;
            opnd_b_q  <= '0;
            orig_a_q  <= '0;
            a_neg_q   <= 1'b0;
            b_neg_q   <= 1'b0;
            is_div_q  <= 1'b0;
            hi_q      <= '0;
            lo_q      <= '0;
            pend_q    <= 1'b0;
            pend_hi_q <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (is_arith) begin
                        step_q   <= '0;
                        acc_hi_q <= '0;
                        acc_lo_q <= mag_a;
                        opnd_b_q <= mag_b;
                        orig_a_q <= op_a_i;
                        a_neg_q  <= a_neg;
                        b_neg_q  <= b_neg;
                        is_div_q <= cmd_i[1];
                    end else if (is_move) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= move_hi ? hi_q : lo_q;
                    end
                end
                ST_MUL, ST_DIV: begin
                    step_q   <= step_q + 1'b1;
                    acc_hi_q <= (state_q == ST_DIV) ? div_rem : mul_hi;
                    acc_lo_q <= (state_q == ST_DIV) ? div_quo : mul_lo;
                    if (is_move && !pend_q) begin
                        pend_q    <= 1'b1;
                        pend_hi_q <= move_hi;
                    end
                end
                ST_FIX: begin
                    hi_q   <= fin_hi;
                    lo_q   <= fin_lo;
                    pend_q <= 1'b0;
                    if (pend_q || is_move) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= (pend_q ? pend_hi_q : move_hi) ? fin_hi : fin_lo;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        rd_valid_o = rd_valid_q;
        rd_data_o  = rd_data_q;
    end

endmodule

// File: rtl/hilo_muldiv_checker.sv
module hilo_muldiv_checker #(
    parameter int WIDTH = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] cmd_i,
    input logic       busy_o,
    input logic       rd_valid_o
);
    localparam int CW = $clog2(WIDTH + 2) + 1;
    localparam logic [CW-1:0] RUN_LEN = CW'(WIDTH + 1);
    localparam logic [CW-1:0] ITER    = CW'(WIDTH);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !cmd_i[2]) |=> busy_o);

    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt == RUN_LEN));

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_cnt < ITER) |=> busy_o);

    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !busy_o);

    p_idle_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (cmd_i == 3'd4 || cmd_i == 3'd5)) |=> (rd_valid_o && !busy_o));

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && cmd_i[2:1] == 2'b11) |=> (!busy_o && !rd_valid_o));

endmodule

bind hilo_muldiv hilo_muldiv_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmd_i      (cmd_i),
    .busy_o     (busy_o),
    .rd_valid_o (rd_valid_o)
);

// File: tb/hilo_muldiv_bench.sv
module hilo_muldiv_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  cmd_i = 3'd0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        busy_o;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    hilo_muldiv u_hilo_muldiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmd_i      (cmd_i),
        .op_a_i     (op_a_i),
        .op_b_i     (op_b_i),
        .busy_o     (busy_o),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    // {cmd, a, b}
    localparam int NV = 14;
    localparam logic [66:0] VEC [NV] = '{
        {3'd0, 32'd7,          32'd6},
        {3'd0, 32'hFFFFFFFF,   32'hFFFFFFFF},
        {3'd0, 32'd0,          32'hDEADBEEF},
        {3'd1, 32'hFFFFFFFD,   32'd5},
        {3'd1, 32'h80000000,   32'h80000000},
        {3'd1, 32'hFFFFFFFF,   32'hFFFFFFFF},
        {3'd2, 32'd100,        32'd7},
        {3'd2, 32'hFFFFFFFF,   32'd10},
        {3'd3, 32'hFFFFFFF9,   32'd2},
        {3'd3, 32'd7,          32'hFFFFFFFE},
        {3'd3, 32'hFFFFFFF9,   32'hFFFFFFFE},
        {3'd3, 32'h80000000,   32'hFFFFFFFF},
        {3'd2, 32'd1234,       32'd0},
        {3'd3, 32'hFFFFFFF0,   32'd0}
    };

    function automatic logic [63:0] model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        logic signed [63:0] sp;
        logic signed [31:0] q, r;
        case (c)
            3'd0: p = {32'd0, a} * {32'd0, b};
            3'd1: begin
                sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
                p = sp;
            end
            default: begin
                if (b == 0) p = {a, 32'hFFFFFFFF};
                else if (c == 3'd2) p = {a % b, a / b};
                else if (a == 32'h80000000 && b == 32'hFFFFFFFF) p = {32'd0, 32'h80000000};
                else begin
                    q = $signed(a) / $signed(b);
                    r = $signed(a) % $signed(b);
                    p = {r, q};
                end
            end
        endcase
        return p;
    endfunction

    function automatic string tag_of(input logic [2:0] c, input logic [31:0] b);
        if (c[1] && b == 0) return "R5";
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // move read while idle: result valid one cycle after strobe
    task automatic read_reg(input logic hi, input string tag, input logic [31:0] exp);
        @(negedge clk);
        start_i = 1'b1;
        cmd_i = hi ? 3'd4 : 3'd5;
        @(negedge clk);
        start_i = 1'b0;
        check(tag, "read valid", {31'd0, rd_valid_o}, 32'd1);
        check(tag, hi ? "HI" : "LO", rd_data_o, exp);
    endtask

    // run an operation; optionally inject a second strobe at busy cycle inj
    task automatic run_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                          input int inj, input logic [2:0] ic, input logic [31:0] ia,
                          input logic [31:0] ib, output int n, output int vmid);
        @(negedge clk);
        start_i = 1'b1; cmd_i = c; op_a_i = a; op_b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        n = 0; vmid = 0;
        while (busy_o && n < 100) begin
            n++;
            if (rd_valid_o) vmid++;
            if (n == inj) begin
                start_i = 1'b1; cmd_i = ic; op_a_i = ia; op_b_i = ib;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int n, vmid;
        logic [63:0] e;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "busy after reset", {31'd0, busy_o}, 32'd0);
        check("R10", "valid during reset", {31'd0, rd_valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "valid after reset", {31'd0, rd_valid_o}, 32'd0);
        read_reg(1'b1, "R10", 32'd0);
        read_reg(1'b0, "R10", 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [2:0] c;
            logic [31:0] a, b;
            {c, a, b} = VEC[i];
            e = model(c, a, b);
            run_op(c, a, b, 0, 3'd0, 32'd0, 32'd0, n, vmid);
            check("R7", "busy cycles", n, 32'd33);
            check("R8", "valid while busy", vmid, 32'd0);
            read_reg(1'b1, tag_of(c, b), e[63:32]);
            read_reg(1'b0, tag_of(c, b), e[31:0]);
        end

        // R8: move held during the run, answered as busy falls
        run_op(3'd0, 32'd12345, 32'd1000, 3, 3'd5, 32'd0, 32'd0, n, vmid);
        check("R8", "busy cycles", n, 32'd33);
        check("R8", "valid while busy", vmid, 32'd0);
        check("R8", "valid at busy fall", {31'd0, rd_valid_o}, 32'd1);
        check("R8", "held LO", rd_data_o, 32'd12345000);

        // R8: move in the last busy cycle (same cycle as the result write)
        run_op(3'd2, 32'd100, 32'd7, 33, 3'd4, 32'd0, 32'd0, n, vmid);
        check("R8", "valid at busy fall (last cycle)", {31'd0, rd_valid_o}, 32'd1);
        check("R8", "fresh HI", rd_data_o, 32'd2);

        // R9: divide strobed mid-multiply is ignored
        run_op(3'd0, 32'd3, 32'd5, 2, 3'd2, 32'd100, 32'd7, n, vmid);
        check("R9", "busy cycles", n, 32'd33);
        @(negedge clk);
        check("R9", "no second run", {31'd0, busy_o}, 32'd0);
        read_reg(1'b1, "R9", 32'd0);
        read_reg(1'b0, "R9", 32'd15);

        // R11: unused codes 6 and 7 do nothing
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            start_i = 1'b1; cmd_i = 3'(k); op_a_i = 32'd9; op_b_i = 32'd9;
            @(negedge clk);
            start_i = 1'b0;
            check("R11", "busy", {31'd0, busy_o}, 32'd0);
            check("R11", "valid", {31'd0, rd_valid_o}, 32'd0);
        end
        read_reg(1'b1, "R11", 32'd0);
        read_reg(1'b0, "R11", 32'd15);

        // R6: valid is a single pulse when no further move follows
        @(negedge clk);
        check("R6", "valid drops", {31'd0, rd_valid_o}, 32'd0);

        summary();
    end

endmodule